// File: doc/BRIEF.md
# Configurable Array Logic Cell

This block models one fine-grained cell of a programmable logic array. Each of the four neighbours (north, east, south, west) supplies an A bit and a B bit. Two independent selectors each pick one neighbour bit or a constant 1. The selected values enter two AND gates. The left gate's second operand can come from one of the four local bus lines. The right gate's second operand is a configuration bit. A shared two-bit function state then routes the two AND results to the cell's single A and B outputs. Those outputs reach all four neighbours unchanged. The state chooses between straight routing, swapped routing, XOR with NAND, and a registered XOR with AND.

The cell also touches four local bus lines: two run north-south and two run east-west. Each line is modelled as a separate input, a value output and an output enable. The cell can read a line into its datapath and can drive its A output onto a line. That drive is either always on or gated by the selected B input. The cell can also pass a line's value across a 90-degree turn to its partner line. The configuration is a static input word. The register uses the column's clock and an active-low asynchronous reset. A configuration in which any one bus line is used for more than one purpose raises an error flag.

Top module: `logic_cell`

## Requirements
- R1: `a_sel` values 0, 1, 2, 3 select `nb_a[0]` (N), `nb_a[1]` (E), `nb_a[2]` (S), `nb_a[3]` (W), and values 4 to 7 select constant 1. `b_sel` selects from `nb_b` the same way, independently of `a_sel`.
- R2: The left AND operand is the A selection ANDed with a bus term. `rd_sel` 0 or 5 to 7 gives a bus term of constant 1, and `rd_sel` 1 to 4 reads bus line `rd_sel-1`. Bus index 0 is NS1, 1 is EW1, 2 is NS2 and 3 is EW2. The right AND operand is the B selection ANDed with `r_en`.
- R3: In state 0, `out_a` is the left AND and `out_b` is the right AND. In state 1 the two are swapped.
- R4: In state 2, `out_a` is the XOR of the two AND results and `out_b` is their NAND.
- R5: In state 3, `out_b` is the AND of the two AND results and `out_a` is the register output. On each rising clock edge taken while in state 3, the register loads the XOR of the two AND results.
- R6: In states 0 to 2 the register holds its value across clock edges.
- R7: A low `rst_n` clears the register at once, without waiting for a clock edge.
- R8: `wr_sel` 1 to 4 makes the cell drive `out_a` onto bus `wr_sel-1`. With `wr_dyn`=0 the drive is always enabled. With `wr_dyn`=1 it is enabled only while the selected B input is 1. `wr_sel` 0 or 5 to 7 means no write.
- R9: `t1_en` links NS1 with EW1, and `t2_en` links NS2 with EW2. With direction bit 0 the east-west line is driven with the north-south line's input value. With direction bit 1 the north-south line is driven with the east-west line's input value.
- R10: `cfg_err` is 1 exactly when some bus line is the target of more than one of read, write and turn.
- R11: A bus line that is neither written nor turned onto has `bus_oe` 0 and `bus_out` 0.
- R12: `cfg` bit fields, MSB first, are: state [19:18], a_sel [17:15], b_sel [14:12], r_en [11], rd_sel [10:8], wr_sel [7:5], wr_dyn [4], t1_en [3], t1_dir [2], t2_en [1], t2_dir [0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock for the cell register |
| rst_n | input | 1 | Column asynchronous reset, active low |
| cfg | input | 20 | Configuration word, layout in R12 |
| nb_a | input | 4 | A inputs from N, E, S, W (bits 0 to 3) |
| nb_b | input | 4 | B inputs from N, E, S, W (bits 0 to 3) |
| bus_in | input | 4 | Local bus line values NS1, EW1, NS2, EW2 |
| bus_out | output | 4 | Value the cell drives onto each bus line |
| bus_oe | output | 4 | Drive enable for each bus line |
| out_a | output | 1 | A output, shared by all four neighbours |
| out_b | output | 1 | B output, shared by all four neighbours |
| cfg_err | output | 1 | Bus line used by more than one operation |

## Verification
Some relations are checked at every clock edge. In the XOR/NAND state, a high A output forces a high B output. In the registered state, a high B output leaves a zero in the register one edge later. The register stays steady outside the registered state. A bus line that is read while driven, or a line pair driven from both sides, always goes with a raised error flag. The exact truth tables of every state and selector pair can only be shown by the bench's sweeps, and so can each bus-index decode and turn direction. The same holds for the register's load timing and for a reset arriving in the middle of a cycle.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int NB_NUM  = 4;             // neighbours N, E, S, W
  localparam int BUS_NUM = 4;             // NS1, EW1, NS2, EW2
  localparam int PAIR_NUM = BUS_NUM / 2;  // turn pairs
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_XNAND = 2'd2,
    ST_REGX  = 2'd3
  } fn_state_e;

  typedef struct packed {
    fn_state_e        state;
    logic [SEL_W-1:0] a_sel;
    logic [SEL_W-1:0] b_sel;
    logic             r_en;
    logic [SEL_W-1:0] rd_sel;
    logic [SEL_W-1:0] wr_sel;
    logic             wr_dyn;
    logic             t1_en;
    logic             t1_dir;
    logic             t2_en;
    logic             t2_dir;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/lcell_in_mux.sv
// Selects din[sel] when sel < N, otherwise constant 1.
module lcell_in_mux #(
  parameter int N  = 4,
  parameter int SW = 3
) (
  input  logic [SW-1:0] sel,
  input  logic [N-1:0]  din,
  output logic          dout
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    if (int'(sel) < N) dout = din[sel[IW-1:0]];
    else               dout = 1'b1;
  end
endmodule

// File: rtl/lcell_core.sv
module lcell_core
  import lcell_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  fn_state_e state,
  input  logic      a_in,
  input  logic      l_in,
  input  logic      b_in,
  input  logic      r_en,
  output logic      out_a,
  output logic      out_b
);
  logic left_and, right_and, x_val, n_val, q_reg;

  assign left_and  = a_in & l_in;
  assign right_and = b_in & r_en;
  assign x_val     = left_and ^ right_and;
  assign n_val     = left_and & right_and;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q_reg <= 1'b0;
    else if (state == ST_REGX) q_reg <= x_val;
  end

  always_comb begin
    unique case (state)
      ST_PASS:  begin out_a = left_and;  out_b = right_and; end
      ST_SWAP:  begin out_a = right_and; out_b = left_and;  end
      ST_XNAND: begin out_a = x_val;     out_b = ~n_val;    end
      default:  begin out_a = q_reg;     out_b = n_val;     end
    endcase
  end

  AST_XNAND_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XNAND && out_a) |-> out_b); // R4
  AST_AND_CLEARS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REGX && out_b) |=> !q_reg); // R5
  AST_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_REGX) |=> $stable(q_reg)); // R6
endmodule

// File: rtl/lcell_bus.sv
module lcell_bus
  import lcell_pkg::*;
#(
  parameter int NBUS  = BUS_NUM,
  parameter int NPAIR = NBUS / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_dyn,
  input  logic             b_sel_val,
  input  logic             drive_val,
  input  logic [NPAIR-1:0] turn_en,
  input  logic [NPAIR-1:0] turn_dir,
  input  logic [NBUS-1:0]  bus_in,
  output logic [NBUS-1:0]  bus_out,
  output logic [NBUS-1:0]  bus_oe,
  output logic             cfg_err
);
  logic            wr_go;
  logic [NBUS-1:0] rd_vec, over;

  assign wr_go = wr_dyn ? b_sel_val : 1'b1;

  for (genvar i = 0; i < NBUS; i++) begin : g_line
    localparam int  PAIR  = i / 2;
    localparam int  PEER  = i ^ 1;
    localparam bit  IS_EW = (i % 2) == 1;
    logic       wr_hit, t_en, t_drv;
    logic [1:0] uses;

    assign wr_hit    = (wr_sel == SEL_W'(i + 1));
    assign rd_vec[i] = (rd_sel == SEL_W'(i + 1));
    assign t_en      = turn_en[PAIR];
    // direction 0: north-south to east-west; 1: east-west to north-south
    assign t_drv     = t_en && (turn_dir[PAIR] != IS_EW);

    assign bus_oe[i]  = (wr_hit && wr_go) || t_drv;
    assign bus_out[i] = (wr_hit && wr_go) ? drive_val :
                        (t_drv ? bus_in[PEER] : 1'b0);

    assign uses    = 2'(rd_vec[i]) + 2'(wr_hit) + 2'(t_en);
    assign over[i] = (uses > 2'd1);
  end

  assign cfg_err = |over;

  AST_READ_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_vec & bus_oe)) |-> cfg_err); // R10
  AST_PAIR_BOTH_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((&bus_oe[1:0]) || (&bus_oe[3:2])) |-> cfg_err); // R10
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lcell_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg,
  input  logic [NB_NUM-1:0]  nb_a,
  input  logic [NB_NUM-1:0]  nb_b,
  input  logic [BUS_NUM-1:0] bus_in,
  output logic [BUS_NUM-1:0] bus_out,
  output logic [BUS_NUM-1:0] bus_oe,
  output logic               out_a,
  output logic               out_b,
  output logic               cfg_err
);
  cell_cfg_t c;
  logic      a_val, b_val, l_val;

  assign c = cell_cfg_t'(cfg);

  lcell_in_mux #(.N(NB_NUM), .SW(SEL_W)) u_amux (
    .sel(c.a_sel), .din(nb_a), .dout(a_val));

  lcell_in_mux #(.N(NB_NUM), .SW(SEL_W)) u_bmux (
    .sel(c.b_sel), .din(nb_b), .dout(b_val));

  // index 0 is the constant-1 choice, 1..BUS_NUM are the bus lines
  lcell_in_mux #(.N(BUS_NUM + 1), .SW(SEL_W)) u_rdmux (
    .sel(c.rd_sel), .din({bus_in, 1'b1}), .dout(l_val));

  lcell_core u_core (
    .clk(clk), .rst_n(rst_n), .state(c.state),
    .a_in(a_val), .l_in(l_val), .b_in(b_val), .r_en(c.r_en),
    .out_a(out_a), .out_b(out_b));

  lcell_bus #(.NBUS(BUS_NUM)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .rd_sel(c.rd_sel), .wr_sel(c.wr_sel), .wr_dyn(c.wr_dyn),
    .b_sel_val(b_val), .drive_val(out_a),
    .turn_en({c.t2_en, c.t1_en}), .turn_dir({c.t2_dir, c.t1_dir}),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .cfg_err(cfg_err));
endmodule

// File: tb/tb_logic_cell.sv
module tb_logic_cell;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [19:0] cfg;
  logic [3:0] nb_a, nb_b, bus_in, bus_out, bus_oe;
  logic       out_a, out_b, cfg_err;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  logic_cell dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .nb_a(nb_a), .nb_b(nb_b),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .out_a(out_a), .out_b(out_b), .cfg_err(cfg_err));

  // R12 field layout, MSB first
  function automatic logic [19:0] mk(input int st, input int a, input int b,
      input int ren, input int rd, input int wr, input int dyn,
      input int t1e, input int t1d, input int t2e, input int t2d);
    return {2'(st), 3'(a), 3'(b), 1'(ren), 3'(rd), 3'(wr), 1'(dyn),
            1'(t1e), 1'(t1d), 1'(t2e), 1'(t2d)};
  endfunction

  function automatic logic pick(input int sel, input logic [3:0] v);
    return (sel < 4) ? v[sel] : 1'b1;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nb_a = '0; nb_b = '0; bus_in = '0;
    cfg = mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    #(CLK_P * 2 + 1);
    chk("R7 reset clears register", {3'b0, out_a}, 4'b0);
    chk("R11 idle buses oe", bus_oe, 4'b0);
    chk("R11 idle buses out", bus_out, 4'b0);
    chk("R10 no error", {3'b0, cfg_err}, 4'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R3 R4 R5: sweep states, selectors and neighbour values
    for (int st = 0; st < 4; st++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 5; b++)
          for (int ren = 0; ren < 2; ren++)
            for (int na = 0; na < 16; na++)
              for (int nb = 0; nb < 16; nb++) begin
                logic l, r, ea, eb;
                cfg = mk(st, a, b, ren, 0, 0, 0, 0, 0, 0, 0);
                nb_a = 4'(na); nb_b = 4'(nb);
                l = pick(a, nb_a);
                r = pick(b, nb_b) & 1'(ren);
                case (st)
                  0: begin ea = l; eb = r; end
                  1: begin ea = r; eb = l; end
                  2: begin ea = l ^ r; eb = ~(l & r); end
                  default: begin ea = 1'b0; eb = l & r; end
                endcase
                #1;
                if (st < 2) begin
                  chk("R1/R3 out_a", {3'b0, out_a}, {3'b0, ea});
                  chk("R1/R3 out_b", {3'b0, out_b}, {3'b0, eb});
                end else if (st == 2) begin
                  chk("R4 xor out_a", {3'b0, out_a}, {3'b0, ea});
                  chk("R4 nand out_b", {3'b0, out_b}, {3'b0, eb});
                end else begin
                  chk("R5 and out_b", {3'b0, out_b}, {3'b0, eb});
                end
                #1;
              end

    // R2: bus read as left operand, right side gated off
    for (int rd = 0; rd < 8; rd++)
      for (int bv = 0; bv < 16; bv++)
        for (int n0 = 0; n0 < 2; n0++) begin
          logic lb;
          cfg = mk(0, 0, 4, 0, rd, 0, 0, 0, 0, 0, 0);
          bus_in = 4'(bv); nb_a = 4'(n0); nb_b = 4'hF;
          lb = (rd >= 1 && rd <= 4) ? bus_in[rd - 1] : 1'b1;
          #1;
          chk("R2 left operand read", {3'b0, out_a}, {3'b0, 1'(n0) & lb});
          chk("R2 right operand r_en=0", {3'b0, out_b}, 4'b0);
          #1;
        end
    bus_in = '0;

    // R5 R6 R7: register timing
    @(negedge clk);
    cfg = mk(3, 0, 4, 0, 0, 0, 0, 0, 0, 0, 0); nb_a = 4'b0001;
    #1 chk("R5 no load before edge", {3'b0, out_a}, 4'b0);
    @(posedge clk); #1 chk("R5 load xor=1", {3'b0, out_a}, 4'b1);
    cfg = mk(3, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0);
    #1 chk("R5 and out_b", {3'b0, out_b}, 4'b1);
    @(posedge clk); #1 chk("R5 load xor=0", {3'b0, out_a}, 4'b0);
    cfg = mk(3, 0, 4, 0, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #1 chk("R5 load xor=1 again", {3'b0, out_a}, 4'b1);
    cfg = mk(0, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0); nb_a = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cfg = mk(3, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0);
    #1 chk("R6 held outside state 3", {3'b0, out_a}, 4'b1);
    #1 rst_n = 1'b0;
    #1 chk("R7 async clear mid-cycle", {3'b0, out_a}, 4'b0);
    @(negedge clk); rst_n = 1'b1;

    // R8 write paths (state 0, out_a = nb_a[0])
    cfg = mk(0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0); nb_a = 4'b0001;
    #1 chk("R8 always write oe", bus_oe, 4'b0010);
    chk("R8 write value 1", bus_out, 4'b0010);
    nb_a = 4'b0000;
    #1 chk("R8 write value 0", bus_out, 4'b0000);
    chk("R10 single write legal", {3'b0, cfg_err}, 4'b0);
    cfg = mk(0, 0, 0, 0, 0, 4, 1, 0, 0, 0, 0); nb_a = 4'b0001; nb_b = 4'b0000;
    #1 chk("R8 dynamic write off", bus_oe, 4'b0000);
    chk("R11 undriven value", bus_out, 4'b0000);
    nb_b = 4'b0001;
    #1 chk("R8 dynamic write on", bus_oe, 4'b1000);
    chk("R8 dynamic write value", bus_out, 4'b1000);
    cfg = mk(0, 0, 0, 0, 0, 5, 0, 0, 0, 0, 0);
    #1 chk("R8 wr_sel 5 no write", bus_oe, 4'b0000);

    // R9 turns
    cfg = mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); bus_in = 4'b0001;
    #1 chk("R9 NS1 to EW1 oe", bus_oe, 4'b0010);
    chk("R9 NS1 to EW1 val", bus_out, 4'b0010);
    cfg = mk(0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0); bus_in = 4'b0010;
    #1 chk("R9 EW1 to NS1 oe", bus_oe, 4'b0001);
    chk("R9 EW1 to NS1 val", bus_out, 4'b0001);
    cfg = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0); bus_in = 4'b0100;
    #1 chk("R9 NS2 to EW2", bus_out & bus_oe, 4'b1000);
    chk("R9 NS2 to EW2 oe", bus_oe, 4'b1000);
    cfg = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1); bus_in = 4'b0000;
    #1 chk("R9 EW2 to NS2 oe, value 0", {bus_oe[3:2], bus_out[3:2]}, 4'b0100);

    // R10 conflict flag
    cfg = mk(0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    #1 chk("R10 read+write NS1", {3'b0, cfg_err}, 4'b1);
    cfg = mk(0, 0, 0, 0, 3, 0, 0, 0, 0, 1, 0);
    #1 chk("R10 read NS2 + turn", {3'b0, cfg_err}, 4'b1);
    cfg = mk(0, 0, 0, 0, 0, 4, 0, 0, 0, 1, 1);
    #1 chk("R10 write EW2 + turn", {3'b0, cfg_err}, 4'b1);
    cfg = mk(0, 0, 0, 0, 0, 2, 0, 1, 0, 0, 0);
    #1 chk("R10 write EW1 + turn", {3'b0, cfg_err}, 4'b1);
    cfg = mk(0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
    #1 chk("R10 distinct lines legal", {3'b0, cfg_err}, 4'b0);
    cfg = mk(0, 0, 0, 0, 2, 0, 0, 0, 0, 1, 0);
    #1 chk("R10 read EW1, turn pair 2 legal", {3'b0, cfg_err}, 4'b0);

    @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule